// File: doc/BRIEF.md
# Programmable Power-of-Two Frequency Divider

This block divides a gated count clock by a power of two chosen at run time. A binary counter chain advances once for every count event. A binary program code selects one stage of that chain, and that stage drives the output `q`. The result is a square wave whose period is 2^n count events, where n is the program code. Programming the code to 10, 20, 26 or 31 turns a 1 MHz count rate into periods of about 1.024 ms, 1.05 s, 1.12 min and 35.79 min.

The count clock is built from two inputs, `cnt_a` and `cnt_b`, so either input can gate the other. A count event is a rising edge of their logical AND, sampled on the system clock. An active-low synchronous clear zeroes every stage and stops counting while it is held. A few fixed intermediate stages drive observation-only tap outputs.

A parameter picks one of two variants:
- the long variant has 31 stages, a 5-bit code and three taps;
- the short variant has 15 stages, a 4-bit code and one tap.

Several dividers can be cascaded, with one block's `q` feeding the next block's count input.

Top module: `pwr2_divider`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, every stage is zeroed. `q` and all `tp` bits then read 0.
- R2: For a program code n with n at least 2, `q` equals bit n-1 of the number of count events since the last clear. In other words, `q` is a 50% duty square wave with a period of 2^n count events.
- R3: Program codes 0 and 1 behave exactly like code 2, giving a minimum modulus of 4.
- R4: One count event occurs per rising edge of (`cnt_a` AND `cnt_b`). Holding one input high lets the other input count. Holding one input low stops counting, and a held-high AND counts only once.
- R5: While `clr_n` is low at a rising `clk` edge, all stages are zeroed and count events are discarded. After release, `q` is low and counting restarts from zero.
- R6: Each `tp` bit is a fixed counter stage. In the long variant `tp[0]`, `tp[1]` and `tp[2]` are stages 5, 15 and 25. In the short variant `tp[0]` is stage 7. Stage k is bit k-1 of the event count.
- R7: `q` and `tp` reflect a count event no later than the third rising `clk` edge after the AND of the inputs is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Synchronous active-low clear of the counter chain |
| cnt_a | input | 1 | Count input A, synchronous to `clk` |
| cnt_b | input | 1 | Count input B, synchronous to `clk` |
| prog | input | 5 (long) / 4 (short) | Binary code n selecting a modulus of 2^n |
| q | output | 1 | Divided square-wave output |
| tp | output | 3 (long) / 1 (short) | Observation taps on fixed stages |

## Verification
The bench tries the division function with several kinds of stimulus:
- **Count-pattern table.** A table of codes and event counts is applied, with the count cleared before each entry. Because `q` must match a single bit of the count, off-by-one errors in stage selection are told apart from errors in the counter itself.
- **Codes 0 and 1.** These are run against the same counts as code 2, which exposes a missing or wrong minimum clamp.
- **Full period.** A period of `q` is measured in events, to confirm the 2^n period and the 50% duty.
- **Gating.** Pulsing `cnt_a` with `cnt_b` low, then pulsing `cnt_b` with `cnt_a` high, separates correct AND gating from a single-input count. Holding both inputs high for many cycles shows that a level is not counted repeatedly.
- **Long run.** A run of 16384 events reaches the middle tap and code 15.

// File: rtl/pwr2div_pkg.sv
// Package: shared sizing helpers for the power-of-two divider.
// Assumes the variant is chosen by one bit: 1 = long chain, 0 = short chain.
package pwr2div_pkg;

    // Number of counter stages for a variant.
    function automatic int stage_count(input bit long_chain);
        return long_chain ? 31 : 15;
    endfunction

    // Width of the binary program code for a variant.
    function automatic int code_width(input bit long_chain);
        return long_chain ? 5 : 4;
    endfunction

    // Number of observation taps for a variant.
    function automatic int tap_count(input bit long_chain);
        return long_chain ? 3 : 1;
    endfunction

endpackage

// File: rtl/count_gate.sv
// count_gate: forms single-cycle count events from two sampled count inputs.
// An event is a rising edge of (in_a AND in_b) as seen on the system clock.
// Assumes in_a and in_b are already synchronous to clk.
module count_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic in_a,
    input  logic in_b,
    output logic evt
);

    logic both_q;
    logic both_d;

    // Sample the gated level and keep its previous value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            both_q <= 1'b0;
            both_d <= 1'b0;
        end else begin
            both_q <= in_a & in_b;
            both_d <= both_q;
        end
    end

    // One event per rising edge of the sampled AND.
    always_comb begin
        evt = both_q & ~both_d;
    end

    // R4: an event never lasts two cycles in a row.
    p_single_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

    // R4: an event follows a cycle in which the inputs' AND was sampled high.
    p_event_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(both_q) |-> evt);

endmodule

// File: rtl/stage_chain.sv
// stage_chain: binary counter of STAGES flops; stage k is bit k-1.
// Advances by one on each count event; a low clear_n zeroes it and wins.
// Assumes evt is at most one cycle wide.
module stage_chain #(
    parameter int STAGES = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_n,
    input  logic              evt,
    output logic [STAGES-1:0] stages
);

    // Reset and clear take priority; otherwise count events.
    always_ff @(posedge clk) begin
        if (!rst_n || !clear_n) begin
            stages <= '0;
        end else if (evt) begin
            stages <= stages + 1'b1;
        end
    end

    // R5: a clear leaves every stage at zero on the next cycle.
    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |=> (stages == '0));

    // R2: an event moves the chain by exactly one.
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && evt) |=> (stages == $past(stages) + 1'b1));

    // R4: without an event the chain holds.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && !evt) |=> $stable(stages));

endmodule

// File: rtl/tap_select.sv
// tap_select: picks the output stage from the program code and drives taps.
// Codes below MIN_CODE clamp up to it; codes above STAGES clamp down.
// Assumes TAP_POS holds 1-based stage numbers within 1..STAGES.
module tap_select #(
    parameter int STAGES   = 31,
    parameter int CODE_W   = 5,
    parameter int MIN_CODE = 2,
    parameter int NTAP     = 3,
    parameter int TAP_POS [NTAP] = '{5, 15, 25}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAGES-1:0] stages,
    input  logic [CODE_W-1:0] code,
    output logic              q,
    output logic [NTAP-1:0]   taps
);

    localparam int IDX_W = $clog2(STAGES + 1);

    logic [IDX_W-1:0] sel;

    // Clamp the code into the usable stage range.
    always_comb begin
        if (int'(code) < MIN_CODE) begin
            sel = IDX_W'(MIN_CODE);
        end else if (int'(code) > STAGES) begin
            sel = IDX_W'(STAGES);
        end else begin
            sel = IDX_W'(code);
        end
    end

    // Output the selected stage (stage n is bit n-1).
    always_comb begin
        q = stages[sel - 1'b1];
    end

    // Fixed observation taps.
    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        assign taps[i] = stages[TAP_POS[i] - 1];
    end

    // R3: a code of 0 or 1 gives the same output as code 2.
    p_min_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(code) < MIN_CODE) |-> (q == stages[MIN_CODE - 1]));

endmodule

// File: rtl/pwr2_divider.sv
// pwr2_divider: programmable 2^n divider with a two-input gated count clock.
// LONG_CHAIN = 1 gives 31 stages, a 5-bit code and three taps;
// LONG_CHAIN = 0 gives 15 stages, a 4-bit code and one tap.
// Assumes cnt_a, cnt_b, clr_n and prog are synchronous to clk.
module pwr2_divider #(
    parameter bit LONG_CHAIN = 1'b1,
    parameter int TAP_A      = 5,
    parameter int TAP_B      = 15,
    parameter int TAP_C      = 25,
    parameter int TAP_SHORT  = 7,
    parameter int MIN_CODE   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic cnt_a,
    input  logic cnt_b,
    input  logic [pwr2div_pkg::code_width(LONG_CHAIN)-1:0] prog,
    output logic q,
    output logic [pwr2div_pkg::tap_count(LONG_CHAIN)-1:0] tp
);

    localparam int STAGES = pwr2div_pkg::stage_count(LONG_CHAIN);
    localparam int CODE_W = pwr2div_pkg::code_width(LONG_CHAIN);
    localparam int NTAP   = pwr2div_pkg::tap_count(LONG_CHAIN);

    logic              evt;
    logic [STAGES-1:0] stages;

    count_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .in_a  (cnt_a),
        .in_b  (cnt_b),
        .evt   (evt)
    );

    stage_chain #(.STAGES(STAGES)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_n (clr_n),
        .evt     (evt),
        .stages  (stages)
    );

    // The tap list depends on the variant.
    if (LONG_CHAIN) begin : g_long
        tap_select #(
            .STAGES   (STAGES),
            .CODE_W   (CODE_W),
            .MIN_CODE (MIN_CODE),
            .NTAP     (NTAP),
            .TAP_POS  ('{TAP_A, TAP_B, TAP_C})
        ) u_sel (
            .clk    (clk),
            .rst_n  (rst_n),
            .stages (stages),
            .code   (prog),
            .q      (q),
            .taps   (tp)
        );
    end else begin : g_short
        tap_select #(
            .STAGES   (STAGES),
            .CODE_W   (CODE_W),
            .MIN_CODE (MIN_CODE),
            .NTAP     (NTAP),
            .TAP_POS  ('{TAP_SHORT})
        ) u_sel (
            .clk    (clk),
            .rst_n  (rst_n),
            .stages (stages),
            .code   (prog),
            .q      (q),
            .taps   (tp)
        );
    end

    // R5: the output is low in the cycle after a clear.
    p_q_low_after_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> !q);

    // R1: reset leaves the output and taps low.
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> (!q && tp == '0));

    // R4: the output cannot change without a count event or a clear.
    p_q_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !evt && $stable(prog)) |=> $stable(q));

endmodule

// File: tb/pwr2_divider_bench.sv
// Self-checking bench for pwr2_divider (long variant, defaults).
module pwr2_divider_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_n = 1'b1;
    logic       cnt_a = 1'b0;
    logic       cnt_b = 1'b1;
    logic [4:0] prog = 5'd2;
    logic       q;
    logic [2:0] tp;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pwr2_divider u_pwr2_divider (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n),
        .cnt_a (cnt_a),
        .cnt_b (cnt_b),
        .prog  (prog),
        .q     (q),
        .tp    (tp)
    );

    // code, event count
    localparam int VEC [10][2] = '{
        '{2, 5}, '{3, 11}, '{4, 20}, '{0, 3}, '{1, 6},
        '{5, 40}, '{6, 100}, '{7, 200}, '{2, 2}, '{8, 383}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One event on cnt_a (cnt_b must be high): two cycles per event.
    task automatic pulse_a(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) cnt_a = 1'b1;
            @(negedge clk) cnt_a = 1'b0;
        end
    endtask

    task automatic pulse_b(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) cnt_b = 1'b1;
            @(negedge clk) cnt_b = 1'b0;
        end
    endtask

    task automatic do_clear();
        @(negedge clk) clr_n = 1'b0;
        @(negedge clk) clr_n = 1'b1;
    endtask

    function automatic logic bit_of(input int n, input int code);
        int e = (code < 2) ? 2 : code;
        return logic'((n >> (e - 1)) & 1);
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int rise1;
        int rise2;
        int highs;
        logic prev;
        idle(3);
        chk("R1 q after reset", q, 1'b0);
        chk("R1 tp after reset", logic'(tp != 0), 1'b0);
        @(negedge clk) rst_n = 1'b1;
        cnt_b = 1'b1;

        // Table walk: R2/R3 for q, R6 for tp[0] (stage 5), R7 via a 3-cycle wait.
        for (int v = 0; v < 10; v++) begin
            do_clear();
            prog = 5'(VEC[v][0]);
            pulse_a(VEC[v][1]);
            idle(3);
            chk((VEC[v][0] < 2) ? "R3 clamped code" : "R2 q stage", q,
                bit_of(VEC[v][1], VEC[v][0]));
            chk("R6 tp0 stage 5", tp[0], logic'((VEC[v][1] >> 4) & 1));
        end

        // R2: measure one full period and the high time for code 3.
        do_clear();
        prog = 5'd3;
        rise1 = -1; rise2 = -1; highs = 0;
        prev = q;
        for (int i = 1; i <= 40; i++) begin
            pulse_a(1);
            idle(2);
            if (q && !prev) begin
                if (rise1 < 0) rise1 = i;
                else if (rise2 < 0) rise2 = i;
            end
            if (rise1 >= 0 && rise2 < 0 && q) highs++;
            prev = q;
        end
        checks++;
        if (rise2 - rise1 != 8) begin
            fails++;
            $display("FAIL R2 period: actual %0d expected 8", rise2 - rise1);
        end
        checks++;
        if (highs != 4) begin
            fails++;
            $display("FAIL R2 duty: actual %0d expected 4", highs);
        end

        // R7: output visible by the third edge after the AND is sampled.
        do_clear();
        prog = 5'd2;
        pulse_a(1);
        @(negedge clk) cnt_a = 1'b1;
        idle(2);
        chk("R7 latency", q, 1'b1);
        cnt_a = 1'b0;

        // R4: cnt_b low blocks cnt_a.
        do_clear();
        prog = 5'd2;
        cnt_b = 1'b0;
        pulse_a(2);
        idle(3);
        chk("R4 gated off", q, 1'b0);
        // R4: cnt_a high lets cnt_b count.
        @(negedge clk) cnt_a = 1'b1;
        pulse_b(2);
        idle(3);
        chk("R4 b counts", q, 1'b1);
        // R4: a held-high AND counts once (two long holds = two events).
        do_clear();
        cnt_a = 1'b1;
        @(negedge clk) cnt_b = 1'b1;
        idle(10);
        @(negedge clk) cnt_b = 1'b0;
        idle(3);
        chk("R4 level counted once", q, 1'b0);
        @(negedge clk) cnt_b = 1'b1;
        idle(10);
        idle(3);
        chk("R4 second level", q, 1'b1);
        cnt_a = 1'b0;

        // R5: clear zeroes and discards events while held.
        do_clear();
        pulse_a(2);
        idle(3);
        chk("R5 before clear", q, 1'b1);
        @(negedge clk) clr_n = 1'b0;
        @(negedge clk);
        chk("R5 clear zeroes", q, 1'b0);
        pulse_a(3);
        idle(2);
        chk("R5 events ignored in clear", q, 1'b0);
        clr_n = 1'b1;
        idle(2);
        chk("R5 low after release", q, 1'b0);
        pulse_a(2);
        idle(3);
        chk("R5 restart from zero", q, 1'b1);

        // R1: mid-run reset.
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk("R1 mid-run reset", q, 1'b0);

        // R6 and R2: long run reaches stage 15 and code 15.
        do_clear();
        prog = 5'd15;
        pulse_a(16384);
        idle(3);
        chk("R2 code 15", q, 1'b1);
        chk("R6 tp1 stage 15", tp[1], 1'b1);
        chk("R6 tp2 stage 25", tp[2], 1'b0);
        chk("R6 tp0 stage 5", tp[0], 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule